// File: doc/BRIEF.md
# I2C SCL clock divider

This block derives the serial clock timing for an I2C controller from the module clock. The module clock first passes through a programmable prescaler, which produces a one-cycle tick every prescaler+1 module clocks. Two phase counters run on those ticks. One times the SCL low phase and the other times the high phase. Each phase lasts its programmed count plus a fixed offset. The offset depends only on the prescaler setting and is 7 ticks for a prescaler of 0, 6 ticks for 1, and 5 ticks for anything larger.

Software writes the prescaler, low count and high count over a simple write port. It then sets the run bit of the mode register to release the block. While the run bit is clear the block is held: SCL is high and every counter is cleared. The divider values are captured at release. A write that arrives while the block is running changes nothing until the block is next held and released again. The outputs are the prescaled tick, the SCL level to drive, and one-cycle strobes that mark the start of each low phase and each high phase.

Top module: `scl_clk_divider`

## Requirements
- R1: While the run bit is 0, scl_out is 1 and tick_out, low_start and high_start are 0. This holds from reset, and the run bit resets to 0.
- R2: While running, tick_out is 1 for exactly one module clock in every prescaler+1 module clocks. The first tick comes prescaler+1 cycles after release, counting the first running cycle as cycle 1.
- R3: The phase offset d is 7 when the prescaler is 0, 6 when it is 1, and 5 when it is 2 or larger.
- R4: After release SCL starts in the low phase. The low phase lasts (low count + d) × (prescaler + 1) module clocks, the high phase lasts (high count + d) × (prescaler + 1) module clocks, and the two alternate without end.
- R5: low_start is 1 for exactly the first module clock of every low phase, including the first one after release. high_start is 1 for exactly the first module clock of every high phase.
- R6: Writes to the prescaler, low count or high count while running do not change the SCL timing. The values in the registers at the moment of release are the ones used.
- R7: The register map uses byte offsets 0x30 for the prescaler, 0x0c for the low count and 0x10 for the high count, all 16-bit. The run bit is bit 5 of the mode register at 0x24. The other bits of the mode register, and writes to any other offset, have no effect.
- R8: Clearing the run bit part-way through a phase makes the block held from the next cycle. A later release restarts timing from the start of a low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| scl_out | output | 1 | SCL level to drive |
| tick_out | output | 1 | Prescaled tick, one module clock wide |
| low_start | output | 1 | Pulse on the first cycle of each low phase |
| high_start | output | 1 | Pulse on the first cycle of each high phase |

## Verification
The hardest cases to reach from the ports are the ones where software disturbs a running divider. One is new divider values written in the middle of a period, which must stay invisible until the next release. The other is the run bit being cleared part-way through a phase. The stimulus releases the block with one setting, overwrites all three divider registers while the block runs, and keeps comparing against the old timing. It then holds the block and releases it again, and expects the new timing from the first cycle. Separate runs use prescaler values 0, 1, 2 and 3, so each offset branch is reached. Zero low and high counts are included so that a phase consists of its offset alone.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  localparam int ADDR_LOW  = 'h0c;
  localparam int ADDR_HIGH = 'h10;
  localparam int ADDR_MODE = 'h24;
  localparam int ADDR_PSC  = 'h30;
  localparam int RUN_BIT   = 5;

  // Extra prescaled ticks added to each SCL phase.
  function automatic logic [3:0] phase_offset(input logic is_zero, input logic is_one);
    if (is_zero)     return 4'd7;
    else if (is_one) return 4'd6;
    else             return 4'd5;
  endfunction
endpackage

// File: rtl/scl_div_regs.sv
module scl_div_regs
  import scl_div_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  prog_psc,
  output logic [REG_W-1:0]  prog_low,
  output logic [REG_W-1:0]  prog_high,
  output logic              run
);
  logic [REG_W-1:0] psc_q, psc_n, low_q, low_n, high_q, high_n;
  logic             run_q, run_n;

  always_comb begin
    psc_n  = psc_q;
    low_n  = low_q;
    high_n = high_q;
    run_n  = run_q;
    if (wr_en) begin
      if (addr == ADDR_W'(ADDR_PSC))       psc_n  = wdata;
      else if (addr == ADDR_W'(ADDR_LOW))  low_n  = wdata;
      else if (addr == ADDR_W'(ADDR_HIGH)) high_n = wdata;
      else if (addr == ADDR_W'(ADDR_MODE)) run_n  = wdata[RUN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q  <= '0;
      low_q  <= '0;
      high_q <= '0;
      run_q  <= 1'b0;
    end else begin
      psc_q  <= psc_n;
      low_q  <= low_n;
      high_q <= high_n;
      run_q  <= run_n;
    end
  end

  assign prog_psc  = psc_q;
  assign prog_low  = low_q;
  assign prog_high = high_q;
  assign run       = run_q;
endmodule

// File: rtl/scl_div_prescale.sv
module scl_div_prescale #(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [REG_W-1:0] div,
  output logic             tick
);
  logic [REG_W-1:0] cnt_q, cnt_n;
  logic             wrap;

  assign wrap = (cnt_q == div);
  assign tick = run & wrap;

  always_comb begin
    if (!run)      cnt_n = '0;
    else if (wrap) cnt_n = '0;
    else           cnt_n = cnt_q + REG_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/scl_div_phase.sv
module scl_div_phase
  import scl_div_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [REG_W-1:0] prog_psc,
  input  logic [REG_W-1:0] prog_low,
  input  logic [REG_W-1:0] prog_high,
  output logic [REG_W-1:0] act_psc,
  output logic             scl,
  output logic             low_start,
  output logic             high_start
);
  localparam int PH_W = REG_W + 1;

  logic [REG_W-1:0] psc_q, psc_n, low_q, low_n, high_q, high_n;
  logic [PH_W-1:0]  cnt_q, cnt_n, len;
  logic             high_q_ph, high_n_ph;
  logic             lflip_q, lflip_n, hflip_q, hflip_n;
  logic             run_prev_q;
  logic [3:0]       offs;
  logic             last;

  assign offs = phase_offset(psc_q == '0, psc_q == REG_W'(1));
  assign len  = (high_q_ph ? {1'b0, high_q} : {1'b0, low_q}) + PH_W'(offs);
  assign last = (cnt_q == len - PH_W'(1));

  always_comb begin
    // divider values are frozen while running
    psc_n     = run ? psc_q  : prog_psc;
    low_n     = run ? low_q  : prog_low;
    high_n    = run ? high_q : prog_high;
    cnt_n     = cnt_q;
    high_n_ph = high_q_ph;
    lflip_n   = 1'b0;
    hflip_n   = 1'b0;
    if (!run) begin
      cnt_n     = '0;
      high_n_ph = 1'b0;
    end else if (tick) begin
      if (last) begin
        cnt_n     = '0;
        high_n_ph = ~high_q_ph;
        lflip_n   = high_q_ph;
        hflip_n   = ~high_q_ph;
      end else begin
        cnt_n = cnt_q + PH_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q      <= '0;
      low_q      <= '0;
      high_q     <= '0;
      cnt_q      <= '0;
      high_q_ph  <= 1'b0;
      lflip_q    <= 1'b0;
      hflip_q    <= 1'b0;
      run_prev_q <= 1'b0;
    end else begin
      psc_q      <= psc_n;
      low_q      <= low_n;
      high_q     <= high_n;
      cnt_q      <= cnt_n;
      high_q_ph  <= high_n_ph;
      lflip_q    <= lflip_n;
      hflip_q    <= hflip_n;
      run_prev_q <= run;
    end
  end

  assign act_psc    = psc_q;
  assign scl        = ~run | high_q_ph;
  assign low_start  = run & ((~run_prev_q) | lflip_q);
  assign high_start = run & hflip_q;
endmodule

// File: rtl/scl_clk_divider.sv
module scl_clk_divider #(
  parameter int REG_W  = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic              scl_out,
  output logic              tick_out,
  output logic              low_start,
  output logic              high_start
);
  logic [REG_W-1:0] prog_psc, prog_low, prog_high, act_psc;
  logic             run_q;

  scl_div_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .prog_psc(prog_psc), .prog_low(prog_low),
    .prog_high(prog_high), .run(run_q)
  );

  scl_div_prescale #(.REG_W(REG_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run_q), .div(act_psc), .tick(tick_out)
  );

  scl_div_phase #(.REG_W(REG_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .run(run_q), .tick(tick_out),
    .prog_psc(prog_psc), .prog_low(prog_low), .prog_high(prog_high),
    .act_psc(act_psc), .scl(scl_out), .low_start(low_start),
    .high_start(high_start)
  );
endmodule

// File: rtl/scl_div_checker.sv
module scl_div_checker #(
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             tick,
  input logic             scl,
  input logic             low_start,
  input logic             high_start,
  input logic [REG_W-1:0] act_psc
);
  assert_held_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (scl && !tick && !low_start && !high_start));

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({low_start, high_start}));

  assert_strobe_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (low_start |-> !scl) and (high_start |-> scl));

  assert_scl_edge_marked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && (scl != $past(scl))) |-> (low_start || high_start));

  assert_flip_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (high_start && $past(run)) |-> $past(tick));

  assert_frozen_div_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(act_psc));
endmodule

bind scl_clk_divider scl_div_checker #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run_q), .tick(tick_out), .scl(scl_out),
  .low_start(low_start), .high_start(high_start), .act_psc(act_psc)
);

// File: tb/tb_scl_clk_divider.sv
module tb_scl_clk_divider;
  logic        clk, rst_n, reg_wr_en;
  logic [5:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic        scl_out, tick_out, low_start, high_start;

  scl_clk_divider dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .scl_out(scl_out), .tick_out(tick_out),
    .low_start(low_start), .high_start(high_start)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int vectors = 0, errors = 0, cycles = 0;
  bit cmp_en = 0;
  string cur_req = "R1";

  // behavioural model state
  int m_run = 0, m_psc = 0, m_low = 0, m_high = 0;
  int a_psc = 0, a_low = 0, a_high = 0, elapsed = 0;

  function automatic int offs(int p);
    if (p == 0) return 7;
    if (p == 1) return 6;
    return 5;
  endfunction

  task automatic chk(string sig, string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s (stage %s) cycle %0d: got %0d expected %0d",
               req, sig, cur_req, cycles, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_run = 0; m_psc = 0; m_low = 0; m_high = 0; elapsed = 0;
    end else begin
      int old_run;
      old_run = m_run;
      if (!old_run) begin a_psc = m_psc; a_low = m_low; a_high = m_high; end
      if (reg_wr_en) begin
        case (reg_addr)
          6'h30: m_psc  = reg_wdata;
          6'h0c: m_low  = reg_wdata;
          6'h10: m_high = reg_wdata;
          6'h24: m_run  = reg_wdata[5];
          default: ;
        endcase
      end
      if (m_run && old_run) elapsed++;
      else elapsed = 0;
    end
    #1;
    if (cmp_en) begin
      if (!m_run) begin
        chk("scl_out", "R1", scl_out, 1);
        chk("tick_out", "R1", tick_out, 0);
        chk("low_start", "R1", low_start, 0);
        chk("high_start", "R1", high_start, 0);
      end else begin
        int d, lo_cyc, per, pos;
        d      = offs(a_psc);
        lo_cyc = (a_low + d) * (a_psc + 1);
        per    = lo_cyc + (a_high + d) * (a_psc + 1);
        pos    = elapsed % per;
        chk("scl_out", "R4", scl_out, (pos >= lo_cyc) ? 1 : 0);
        chk("tick_out", "R2", tick_out, ((elapsed % (a_psc + 1)) == a_psc) ? 1 : 0);
        chk("low_start", "R5", low_start, (pos == 0) ? 1 : 0);
        chk("high_start", "R5", high_start, (pos == lo_cyc) ? 1 : 0);
      end
    end
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic wr(input logic [5:0] a, input logic [15:0] v);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(int p, int lo, int hi);
    wr(6'h30, 16'(p)); wr(6'h0c, 16'(lo)); wr(6'h10, 16'(hi));
  endtask

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    #1 cmp_en = 1;
    idle(4);
    rst_n = 1'b1;
    cur_req = "R1"; idle(10);
    // R3 offset 7 with prescaler 0
    cur_req = "R3"; setup(0, 2, 3); wr(6'h24, 16'h0020); idle(60);
    wr(6'h24, 16'h0000);
    // R3 offset 6 with prescaler 1, high count zero
    setup(1, 1, 0); wr(6'h24, 16'h0020); idle(80);
    wr(6'h24, 16'h0000);
    // R3 offset 5 with prescaler 2, low count zero
    setup(2, 0, 4); wr(6'h24, 16'h0020); idle(100);
    // R6 rewrite while running, then rewrite run bit
    cur_req = "R6"; setup(0, 9, 1); wr(6'h24, 16'h0020); idle(60);
    wr(6'h24, 16'h0000); idle(3);
    wr(6'h24, 16'h0020); idle(70);
    // R8 stop mid phase, restart from low
    cur_req = "R8"; wr(6'h24, 16'h0000); idle(5);
    setup(3, 1, 2); wr(6'h24, 16'h0020); idle(17);
    wr(6'h24, 16'h0000); idle(4);
    wr(6'h24, 16'h0020); idle(90);
    // R7 other mode bits and unknown offsets have no effect
    cur_req = "R7"; wr(6'h24, 16'hFFDF); idle(10);
    wr(6'h08, 16'hFFFF); wr(6'h2c, 16'h0020); wr(6'h32, 16'h0001); idle(10);
    wr(6'h24, 16'h0020); idle(90);
    wr(6'h24, 16'h0000); idle(5);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule